// File: doc/BRIEF.md
# RSSI Pseudo-Logarithmic Header Field Encoder

This block turns a linear received-signal-strength reading into a compact 6-bit code that fits the signal-strength field of an outgoing receive-path packet header. Four RSSI sources, one per auxiliary ADC, arrive as 32-bit buses packed side by side. A 2-bit channel index picks the source that belongs to the packet being built. Only the low 16 bits of that bus carry the linear reading.

The linear reading is folded into a small floating-point-like code. A 3-bit exponent sits in the upper half of the code and a 3-bit mantissa in the lower half. Small readings are kept exactly in a linear segment. Larger readings keep their leading one plus the three bits below it. About ten bits of dynamic range therefore fit in six bits, and the code never wraps the way a plain copy of the low six bits would. Readings that are too large for the top exponent saturate to all ones and raise an overrange flag.

The packet builder pulses a capture strobe when it needs the field. One clock later the registered code and flag appear, together with a single-cycle valid pulse. They hold their value until the next capture.

Top module: `rssi_field_encoder`

## Requirements
- R1: `chan_sel` value k (0 to 3) selects the source at bits [32k+31:32k] of `rssi_buses`. Sources that are not selected have no effect on the result.
- R2: Only the low 16 bits of the selected 32-bit source form the linear reading. Its upper 16 bits have no effect.
- R3: A linear reading v below 8 gives the code {3'b000, v[2:0]}, with the exponent in code bits [5:3] and the mantissa in bits [2:0]. A reading of 0 gives code 0x00.
- R4: A linear reading v from 8 to 1023 whose leading one is at bit p (3 to 9) gives exponent p-2 in bits [5:3]. The mantissa in bits [2:0] is v[p-1:p-3], truncated. For example, 8 gives 0x08, 512 gives 0x38 and 1023 gives 0x3F.
- R5: A linear reading of 1024 or more gives code 0x3F with `ovr_o` = 1. Every reading below 1024 gives `ovr_o` = 0.
- R6: The code is monotonic non-decreasing over linear readings 0 to 0xFFFF.
- R7: Inputs are sampled on a clock edge where `capture` is 1. Code and flag appear after that edge, and `valid_o` is 1 for exactly the following cycle. Without a capture, `valid_o` is 0 and the code and flag hold their value.
- R8: When `rst_n` is 0 at a clock edge, the edge clears `code_o`, `ovr_o` and `valid_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| capture | input | 1 | Strobe that samples the channel index and the buses |
| chan_sel | input | 2 | Index of the source for this packet |
| rssi_buses | input | 128 | Four 32-bit RSSI buses; source k at bits [32k+31:32k] |
| code_o | output | 6 | Encoded field: exponent [5:3], mantissa [2:0] |
| ovr_o | output | 1 | Linear reading was 1024 or more |
| valid_o | output | 1 | One-cycle pulse after a capture |

## Verification
A rising sweep of every reading from 0 to 1100 tests the linear segment, each exponent boundary and the saturation edge at 1024. The channel rotates during the sweep, and the sweep checks that each code is never below the one before it. Single captures with large decoy values on the sources that are not selected, and with the upper 16 bits of the selected bus set, show whether the selection and the low-half extraction use the right bits. Values far above 0x7FF, idle cycles between captures and a reset in mid-run show saturation versus wrap, hold versus re-capture, and a cleared output register.

// File: rtl/rssi_enc_pkg.sv
// Package: shared sizing constants for the RSSI field encoder.
// Assumes: the consumer derives every other width from these values.
package rssi_enc_pkg;
    localparam int RSSI_NUM_SRC = 4;   // auxiliary ADC sources
    localparam int RSSI_BUS_W   = 32;  // width of each source bus
    localparam int RSSI_LIN_W   = 16;  // linear reading in the low bits
    localparam int RSSI_EXP_W   = 3;   // exponent bits of the code
    localparam int RSSI_MAN_W   = 3;   // mantissa bits of the code
endpackage

// File: rtl/rssi_src_select.sv
// Module: rssi_src_select
// Picks one source bus out of a packed vector and returns its low LIN_W
// bits as the linear reading.
// Assumes: LIN_W <= BUS_W. An index past NUM_SRC yields zero.
module rssi_src_select #(
    parameter int NUM_SRC = 4,
    parameter int BUS_W   = 32,
    parameter int LIN_W   = 16,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC*BUS_W-1:0] buses,
    input  logic [SEL_W-1:0]         sel,
    output logic [LIN_W-1:0]         lin
);
    logic [LIN_W-1:0] low_part [NUM_SRC];

    // Unpack the low half of every source bus.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign low_part[g] = buses[g*BUS_W +: LIN_W];
    end

    // Pick the variant by whether the index space is fully populated.
    if (NUM_SRC == (1 << SEL_W)) begin : g_full
        // Every index maps to a source.
        assign lin = low_part[sel];
    end else begin : g_partial
        // Indices past the last source read as zero.
        always_comb begin
            lin = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sel == SEL_W'(i)) lin = low_part[i];
            end
        end
    end
endmodule

// File: rtl/rssi_log_encoder.sv
// Module: rssi_log_encoder
// Combinational pseudo-logarithmic encoder. Readings below 2**MAN_W pass
// through in a linear segment with exponent 0. Larger readings keep their
// leading one: exponent = position - (MAN_W-1), and the mantissa is the
// MAN_W bits below it, truncated. Readings at or above
// 2**(MAX_EXP+MAN_W) saturate to all ones and flag overrange.
// Assumes: LIN_W > MAN_W.
module rssi_log_encoder #(
    parameter int LIN_W   = 16,
    parameter int EXP_W   = 3,
    parameter int MAN_W   = 3,
    localparam int CODE_W  = EXP_W + MAN_W,
    localparam int MAX_EXP = (1 << EXP_W) - 1,
    localparam int TOP_BIT = MAX_EXP + MAN_W - 1,
    localparam int LEAD_W  = $clog2(TOP_BIT + 1)
) (
    input  logic [LIN_W-1:0]  lin,
    output logic [CODE_W-1:0] code,
    output logic              ovr
);
    logic [LEAD_W-1:0]  lead;
    logic               normal;
    logic [LEAD_W-1:0]  exp_full;
    logic [TOP_BIT:0]   shifted;
    logic               hi_bits;

    // Overrange detection: any bit above the top coded position.
    if (LIN_W > TOP_BIT + 1) begin : g_hi
        assign hi_bits = |lin[LIN_W-1:TOP_BIT+1];
    end else begin : g_nohi
        assign hi_bits = 1'b0;
    end
    assign ovr = hi_bits;

    // Leading-one search over the normal range; the highest set bit wins.
    always_comb begin
        lead = LEAD_W'(MAN_W);
        for (int i = MAN_W; i <= TOP_BIT; i++) begin
            if (lin[i]) lead = LEAD_W'(i);
        end
    end

    // A reading is normal when any bit at or above MAN_W is set.
    assign normal   = |lin[TOP_BIT:MAN_W];
    assign exp_full = lead - LEAD_W'(MAN_W - 1);
    assign shifted  = lin[TOP_BIT:0] >> (lead - LEAD_W'(MAN_W));

    // Code assembly: saturation, normal segment or linear segment.
    always_comb begin
        if (hi_bits) begin
            code = '1;
        end else if (normal) begin
            code = {exp_full[EXP_W-1:0], shifted[MAN_W-1:0]};
        end else begin
            code = {{EXP_W{1'b0}}, lin[MAN_W-1:0]};
        end
    end
endmodule

// File: rtl/rssi_field_reg.sv
// Module: rssi_field_reg
// Output register for the encoded field. Loads code and flag on a capture
// strobe and raises valid for the next cycle only. Holds otherwise.
// Assumes: synchronous active-low reset.
module rssi_field_reg #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_d,
    input  logic              ovr_d,
    output logic [CODE_W-1:0] code_q,
    output logic              ovr_q,
    output logic              valid_q
);
    // Capture the encoded field and produce the one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            ovr_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= capture;
            if (capture) begin
                code_q <= code_d;
                ovr_q  <= ovr_d;
            end
        end
    end

    // R7: a capture yields valid on the next cycle.
    assert_valid_after_capture_R7: assert property (@(posedge clk)
        disable iff (!rst_n) capture |=> valid_q);

    // R7: without a capture, valid is low and the field holds.
    assert_hold_without_capture_R7: assert property (@(posedge clk)
        disable iff (!rst_n) !capture |=> (!valid_q && $stable(code_q) && $stable(ovr_q)));

    // R5: the overrange flag always comes with an all-ones code.
    assert_ovr_saturates_R5: assert property (@(posedge clk)
        disable iff (!rst_n) ovr_q |-> (code_q == {CODE_W{1'b1}}));

    // R8: a reset edge leaves the register cleared.
    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (code_q == '0 && !ovr_q && !valid_q));
endmodule

// File: rtl/rssi_field_encoder.sv
// Module: rssi_field_encoder (top)
// Selects the RSSI source of the transmitted channel, compresses its
// linear reading into a 3.3 exponent/mantissa code and registers it on a
// capture strobe.
// Assumes: the linear reading sits in the low half of each source bus.
module rssi_field_encoder
    import rssi_enc_pkg::*;
#(
    parameter int NUM_SRC = RSSI_NUM_SRC,
    parameter int BUS_W   = RSSI_BUS_W,
    parameter int LIN_W   = RSSI_LIN_W,
    parameter int EXP_W   = RSSI_EXP_W,
    parameter int MAN_W   = RSSI_MAN_W,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CODE_W = EXP_W + MAN_W,
    localparam int LIMIT  = 1 << ((1 << EXP_W) - 1 + MAN_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic [SEL_W-1:0]         chan_sel,
    input  logic [NUM_SRC*BUS_W-1:0] rssi_buses,
    output logic [CODE_W-1:0]        code_o,
    output logic                     ovr_o,
    output logic                     valid_o
);
    logic [LIN_W-1:0]  sel_lin;
    logic [CODE_W-1:0] enc_code;
    logic              enc_ovr;

    // Source selection for the transmitted channel.
    rssi_src_select #(.NUM_SRC(NUM_SRC), .BUS_W(BUS_W), .LIN_W(LIN_W)) u_sel (
        .buses (rssi_buses),
        .sel   (chan_sel),
        .lin   (sel_lin)
    );

    // Pseudo-logarithmic compression.
    rssi_log_encoder #(.LIN_W(LIN_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_enc (
        .lin  (sel_lin),
        .code (enc_code),
        .ovr  (enc_ovr)
    );

    // Registered output field.
    rssi_field_reg #(.CODE_W(CODE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .code_d  (enc_code),
        .ovr_d   (enc_ovr),
        .code_q  (code_o),
        .ovr_q   (ovr_o),
        .valid_q (valid_o)
    );

    // R3: small readings land unchanged in the linear segment.
    assert_small_linear_R3: assert property (@(posedge clk)
        disable iff (!rst_n)
        (capture && sel_lin < LIN_W'(1 << MAN_W)) |=>
        (code_o == {{EXP_W{1'b0}}, $past(sel_lin[MAN_W-1:0])} && !ovr_o));

    // R5: readings at or past the limit saturate and flag overrange.
    assert_large_saturates_R5: assert property (@(posedge clk)
        disable iff (!rst_n)
        (capture && sel_lin >= LIN_W'(LIMIT)) |=> (ovr_o && code_o == {CODE_W{1'b1}}));

    // R5: readings below the limit never flag overrange.
    assert_no_false_ovr_R5: assert property (@(posedge clk)
        disable iff (!rst_n)
        (capture && sel_lin < LIN_W'(LIMIT)) |=> !ovr_o);
endmodule

// File: tb/sim_rssi_field_encoder.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected fields, the monitor
// compares each valid output against the head of the queue.
module sim_rssi_field_encoder;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         capture;
    logic [1:0]   chan_sel;
    logic [127:0] rssi_buses;
    logic [5:0]   code_o;
    logic         ovr_o;
    logic         valid_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [6:0] exp_q[$];   // {ovr, code}
    string      tag_q[$];
    logic [5:0] mono_prev = 6'h00;
    logic [5:0] last_code = 6'h00;

    always #2.5 clk = ~clk;  // 200 MHz

    rssi_field_encoder u0 (
        .clk(clk), .rst_n(rst_n), .capture(capture), .chan_sel(chan_sel),
        .rssi_buses(rssi_buses), .code_o(code_o), .ovr_o(ovr_o), .valid_o(valid_o)
    );

    // Expected field from the requirement text.
    function automatic logic [6:0] model(input logic [15:0] v);
        int msb;
        logic [15:0] m;
        if (v >= 16'd1024) return {1'b1, 6'h3F};
        if (v < 16'd8) return {1'b0, 3'b000, v[2:0]};
        msb = 3;
        for (int k = 9; k >= 3; k--) begin
            if (v[k]) begin msb = k; break; end
        end
        m = v >> (msb - 3);
        return {1'b0, 3'(msb - 2), m[2:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    // Driver: one capture with a chosen reading on a chosen channel;
    // the other sources carry decoys.
    task automatic send(input string tag, input logic [1:0] ch,
                        input logic [31:0] bus, input logic [31:0] decoy);
        @(negedge clk);
        for (int s = 0; s < 4; s++) rssi_buses[s*32 +: 32] = decoy;
        rssi_buses[ch*32 +: 32] = bus;
        chan_sel = ch;
        capture  = 1'b1;
        exp_q.push_back(model(bus[15:0]));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            capture    = 1'b0;
            rssi_buses = {4{32'hFFFF_FFFF}};
            chan_sel   = ~chan_sel;
        end
    endtask

    // Monitor: pop and compare whenever valid is seen.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && valid_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected valid", 1, 0);
            end else begin
                logic [6:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {25'd0, ovr_o, code_o}, {25'd0, e});
                last_code = e[5:0];
                if (t == "R6") begin
                    check("R6 monotonic", 32'(code_o >= mono_prev), 1);
                    mono_prev = code_o;
                end
            end
        end
    end

    initial begin
        rst_n = 1'b0; capture = 1'b0; chan_sel = 2'd0; rssi_buses = '0;
        repeat (3) @(negedge clk);
        check("R8 reset code", {26'd0, code_o}, 0);
        check("R8 reset ovr", {31'd0, ovr_o}, 0);
        check("R8 reset valid", {31'd0, valid_o}, 0);
        rst_n = 1'b1;

        // R3 / R4 corner values.
        send("R3 zero", 2'd0, 32'd0, 32'd900);
        send("R3 seven", 2'd1, 32'd7, 32'd900);
        send("R4 eight", 2'd2, 32'd8, 32'd0);
        send("R4 512", 2'd3, 32'd512, 32'd0);
        send("R4 1023", 2'd0, 32'd1023, 32'd0);
        send("R4 300", 2'd1, 32'd300, 32'd0);
        // R5 saturation.
        send("R5 1024", 2'd2, 32'd1024, 32'd0);
        send("R5 0x7FF", 2'd3, 32'h7FF, 32'd0);
        send("R5 0xFFFF", 2'd0, 32'hFFFF, 32'd0);
        // R1 each channel with strong decoys; R2 upper half ignored.
        for (int c = 0; c < 4; c++) send("R1 select", 2'(c), 32'd40 + 32'(c), 32'h0000_FFFF);
        send("R2 upper ignored", 2'd1, 32'hFFFF_0005, 32'd0);
        send("R2 upper ignored zero", 2'd2, 32'hABCD_0000, 32'hFFFF);
        idle(4);

        // R7 hold: no valid, field unchanged after idle cycles.
        check("R7 hold valid", {31'd0, valid_o}, 0);
        check("R7 hold code", {26'd0, code_o}, {26'd0, last_code});
        check("R7 queue drained", exp_q.size(), 0);

        // R6 sweep with rotating channels.
        mono_prev = 6'h00;
        for (int v = 0; v <= 1100; v++) begin
            send("R6", 2'(v), 32'(v), 32'h0000_0400);
            if (v % 7 == 6) idle(1);
        end
        idle(4);
        check("R6 queue drained", exp_q.size(), 0);

        // R8 reset in mid-run.
        send("R4 mid", 2'd0, 32'd100, 32'd0);
        idle(2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid reset code", {26'd0, code_o}, 0);
        check("R8 mid reset valid", {31'd0, valid_o}, 0);
        check("R8 mid reset ovr", {31'd0, ovr_o}, 0);
        rst_n = 1'b1;
        idle(2);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule